// File: doc/BRIEF.md
# Multi-Lane Deskew and Reorder Receiver

This block sits on the receive side of a striped multi-lane coding sublayer. Every cycle it takes one 66-bit block from each of `NUM_LANES` physical lanes. The lanes may be skewed against one another by whole blocks, and they may be wired in any order. Each lane carries a lane-unique alignment marker once every `MARK_PERIOD` blocks. A lock machine on each physical lane finds the marker at that period and takes the logical lane number from it.

Each lane feeds a small FIFO. Writing starts on a common marker, so once every lane is locked the FIFO heads hold blocks of the same stripe. The block then reads all FIFOs together and places each head in the output slot of its logical lane. The output word is therefore one full round of the transmit striping, restored to its original order. A cycle whose heads are markers gives no output, so the markers are stripped from the stream.

Typical lane counts are 4 and 20. The skew that can be absorbed is bounded by `FIFO_DEPTH`. A skew beyond that bound raises a sticky error flag.

Top module: `lane_deskew_rx`

## Requirements
- R1: While and directly after reset, `out_valid`, `aligned` and `align_error` are 0.
- R2: A block is a marker only when all of the following hold: bits [65:64] = 2'b10, bits [63:16] = 48'h4DB2_6A19_C7E3, bits [15:8] equal the bitwise inverse of bits [7:0], and the lane number in bits [7:0] is less than `NUM_LANES`. A block with a bad inverse or with an out-of-range number is payload, so a lane that carries only such markers never locks and the output stays idle.
- R3: A lane locks only after two markers with the same number, exactly `MARK_PERIOD` blocks apart. Output therefore cannot start before the second marker period. If a marker is missing at the expected position, that lane loses lock, `aligned` drops, and output resumes only after the lane has locked again.
- R4: Output slot k (bits [k*66 +: 66] of `out_blocks`) carries the block of logical lane k, whatever physical lane it arrived on.
- R5: A relative skew of up to `FIFO_DEPTH`-1 blocks between lanes is compensated without error.
- R6: A skew of `FIFO_DEPTH` or more blocks sets `align_error`. The flag stays set until reset, and no output word is produced.
- R7: Marker blocks never appear at the output. Successive output words carry successive stripe rounds, with no payload block lost or duplicated.
- R8: `aligned` is 1 only when all lanes are locked, every lane number appears exactly once, and every lane FIFO is running. If two lanes carry the same number, no output is produced.
- R9: `out_valid` is 1 only in cycles where `aligned` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One block per lane is present this cycle |
| in_blocks | input | NUM_LANES*66 | Physical lane p at bits [p*66 +: 66] |
| out_valid | output | 1 | out_blocks holds one payload round |
| out_blocks | output | NUM_LANES*66 | Logical lane k at bits [k*66 +: 66] |
| aligned | output | 1 | All lanes locked, numbered uniquely and deskewed |
| align_error | output | 1 | Sticky: skew exceeded the buffer or heads misaligned |

## Verification
Four kinds of stimulus are used. The first is an identity wiring with no skew. The second is randomly shuffled wirings with random skew below the buffer depth. The third is a directed reversed wiring at the largest allowed skew spread. The fourth is a skew of exactly the depth. Together these separate correct reordering and deskew from off-by-one errors in the skew bound. Every output word is compared with the stripe round it should carry, which exposes a dropped, repeated or marker block. Corrupted markers (bad inverse, out-of-range number), a duplicated lane number and one deleted marker after lock show whether marker qualification, the uniqueness check and loss of lock each stop the output and then recover correctly.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  localparam int BLK_W = 66;
  localparam logic [1:0]  MK_SYNC = 2'b10;
  localparam logic [47:0] MK_PAT  = 48'h4DB2_6A19_C7E3;

  typedef enum logic [1:0] {ST_SEARCH, ST_CHECK, ST_LOCKED} lock_state_t;

  function automatic logic is_marker(input logic [BLK_W-1:0] b, input int nl);
    return (b[65:64] == MK_SYNC) && (b[63:16] == MK_PAT) &&
           (b[15:8] == ~b[7:0]) && (int'(b[7:0]) < nl);
  endfunction
endpackage

// File: rtl/lane_lock.sv
module lane_lock
  import lane_deskew_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int MARK_PERIOD = 16384,
  parameter int IDW         = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] blk,
  output logic             locked,
  output logic             marker_ok,
  output logic [IDW-1:0]   lane_id
);
  localparam int CW = $clog2(MARK_PERIOD + 1);

  lock_state_t st;
  logic [CW-1:0] cnt;
  logic is_mk, expect_mk;
  logic [IDW-1:0] mid;

  assign is_mk     = is_marker(blk, NUM_LANES);
  assign mid       = blk[IDW-1:0];
  assign expect_mk = (cnt == CW'(MARK_PERIOD));
  assign marker_ok = (st != ST_SEARCH) && expect_mk && is_mk && (mid == lane_id);
  assign locked    = (st == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SEARCH;
      cnt     <= '0;
      lane_id <= '0;
    end else if (in_valid) begin
      if (st == ST_SEARCH) begin
        if (is_mk) begin
          st      <= ST_CHECK;
          lane_id <= mid;
          cnt     <= CW'(1);
        end
      end else if (expect_mk) begin
        if (marker_ok) begin
          st  <= ST_LOCKED;
          cnt <= CW'(1);
        end else begin
          st  <= ST_SEARCH;
          cnt <= '0;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int WIDTH = 66,
  parameter int DEPTH = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign do_rd = rd && !empty;
  assign do_wr = wr && (!full || do_rd);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end
endmodule

// File: rtl/lane_deskew_rx.sv
module lane_deskew_rx
  import lane_deskew_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int MARK_PERIOD = 16384,
  parameter int FIFO_DEPTH  = 16
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_LANES*BLK_W-1:0] in_blocks,
  output logic                       out_valid,
  output logic [NUM_LANES*BLK_W-1:0] out_blocks,
  output logic                       aligned,
  output logic                       align_error
);
  localparam int IDW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_LANES-1:0] locked, mk_ok, run, start, wr, empty, full, ovf, head_mk, seen;
  logic [IDW-1:0]   lane_id [NUM_LANES];
  logic [BLK_W-1:0] head    [NUM_LANES];
  logic [BLK_W-1:0] slot    [NUM_LANES];
  logic all_locked, perm_ok, ready, rd, mismatch, flush, ovf_any;

  assign all_locked = &locked;

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
    lane_lock #(.NUM_LANES(NUM_LANES), .MARK_PERIOD(MARK_PERIOD), .IDW(IDW)) u_lock (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .blk(in_blocks[p*BLK_W +: BLK_W]),
      .locked(locked[p]), .marker_ok(mk_ok[p]), .lane_id(lane_id[p])
    );

    assign start[p]   = in_valid && mk_ok[p] && locked[p] && all_locked && !run[p];
    assign wr[p]      = in_valid && (run[p] || start[p]);
    assign ovf[p]     = wr[p] && full[p] && !rd;
    assign head_mk[p] = is_marker(head[p], NUM_LANES);

    lane_fifo #(.WIDTH(BLK_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .clr(flush), .wr(wr[p]),
      .wdata(in_blocks[p*BLK_W +: BLK_W]), .rd(rd),
      .rdata(head[p]), .empty(empty[p]), .full(full[p])
    );

    always_ff @(posedge clk) begin
      if (rst || flush) run[p] <= 1'b0;
      else if (start[p]) run[p] <= 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) begin
      seen[k] = 1'b0;
      slot[k] = '0;
      for (int p = 0; p < NUM_LANES; p++) begin
        if (lane_id[p] == IDW'(k)) begin
          seen[k] = 1'b1;
          slot[k] = head[p];
        end
      end
    end
  end

  assign perm_ok  = &seen;
  assign ready    = all_locked && perm_ok && (&run);
  assign rd       = ready && !(|empty);
  assign mismatch = rd && (|head_mk) && !(&head_mk);
  assign ovf_any  = |ovf;
  assign flush    = ovf_any || mismatch || (|(run & ~locked));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      aligned     <= 1'b0;
      align_error <= 1'b0;
    end else begin
      out_valid <= rd && !(|head_mk);
      aligned   <= ready;
      if (ovf_any || mismatch) align_error <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd && !(|head_mk)) begin
      for (int k = 0; k < NUM_LANES; k++) out_blocks[k*BLK_W +: BLK_W] <= slot[k];
    end
  end
endmodule

// File: rtl/lane_deskew_rx_chk.sv
module lane_deskew_rx_chk #(
  parameter int NUM_LANES = 4
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic                 aligned,
  input logic                 align_error,
  input logic [NUM_LANES-1:0] lane_locked,
  input logic [NUM_LANES-1:0] lane_run,
  input logic                 ovf_any
);
  // R9
  p_valid_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> aligned);

  // R8
  p_aligned_locked_r8: assert property (@(posedge clk) disable iff (rst)
    !(&lane_locked) |=> !aligned);

  // R6
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    align_error |=> align_error);

  // R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_any |=> align_error);

  // R3
  p_lock_loss_flush_r3: assert property (@(posedge clk) disable iff (rst)
    (|(lane_run & ~lane_locked)) |=> (lane_run == '0));

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !aligned && !align_error));
endmodule

bind lane_deskew_rx lane_deskew_rx_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .aligned(aligned),
  .align_error(align_error), .lane_locked(locked), .lane_run(run),
  .ovf_any(ovf_any)
);

// File: tb/lane_deskew_rx_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_rx_tb_top;
  localparam int NL = 4;
  localparam int P  = 16;
  localparam int D  = 8;
  localparam int W  = 66;
  localparam logic [47:0] PAT = 48'h4DB2_6A19_C7E3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NL*W-1:0] in_blocks = '0;
  logic out_valid, aligned, align_error;
  logic [NL*W-1:0] out_blocks;

  always #10 clk = ~clk;

  lane_deskew_rx #(.NUM_LANES(NL), .MARK_PERIOD(P), .FIFO_DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_blocks(in_blocks),
    .out_valid(out_valid), .out_blocks(out_blocks),
    .aligned(aligned), .align_error(align_error)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int perm [NL];
  int skew [NL];
  int mode;
  int next_g, words, first_al, words_after;
  bit fell, rose_again, ever_al;

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [W-1:0] payload(input int l, input int q);
    logic [31:0] h;
    h = 32'(q * 40503) ^ 32'(l * 7919);
    return {2'b01, 8'(l), 24'(q), h};
  endfunction

  function automatic logic [W-1:0] lane_blk(input int p, input int t);
    int s;
    logic [7:0] id, cm;
    s = t - skew[p];
    if (s < 0) return {2'b01, 64'h0};
    if (s % P == 0) begin
      if (mode == 4 && p == 1 && s == 4*P) return {2'b01, 64'h0};
      id = 8'(perm[p]);
      if (mode == 3 && p == 2) id = 8'(NL);
      cm = ~id;
      if (mode == 2 && p == 2) cm[0] = ~cm[0];
      return {2'b10, PAT, cm, id};
    end
    return payload(perm[p], s - s/P - 1);
  endfunction

  function automatic logic [NL*W-1:0] exp_word(input int g);
    logic [NL*W-1:0] v;
    for (int k = 0; k < NL; k++) v[k*W +: W] = payload(k, g);
    return v;
  endfunction

  task automatic run_scn(input int cycles);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !aligned && !align_error,
          $sformatf("R1 reset outputs act=%b%b%b exp=000", out_valid, aligned, align_error));
    rst = 1'b0;
    next_g = 2*(P-1); words = 0; first_al = -1; fell = 0; rose_again = 0;
    ever_al = 0; words_after = 0;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (aligned) begin
        ever_al = 1;
        if (first_al < 0) first_al = t;
        if (fell) rose_again = 1;
      end
      if (mode == 4 && !aligned && words > 0 && !fell) begin
        fell = 1;
        next_g = 7*(P-1);
      end
      if (out_valid) begin
        check(aligned, "R9 out_valid without aligned act=0 exp=1");
        check(out_blocks == exp_word(next_g),
              $sformatf("R4 R7 word act=%h exp=%h", out_blocks, exp_word(next_g)));
        next_g++;
        words++;
        if (fell) words_after++;
      end
      for (int p = 0; p < NL; p++) in_blocks[p*W +: W] = lane_blk(p, t);
      in_valid = 1'b1;
    end
  endtask

  task automatic expect_good(input string req);
    check(words >= 5*(P-1), $sformatf("%s word count act=%0d exp>=%0d", req, words, 5*(P-1)));
    check(!align_error, $sformatf("%s align_error act=1 exp=0", req));
    check(aligned, $sformatf("%s aligned at end act=0 exp=1", req));
  endtask

  task automatic expect_idle(input string req);
    check(words == 0, $sformatf("%s words act=%0d exp=0", req, words));
    check(!ever_al, $sformatf("%s aligned seen act=1 exp=0", req));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // identity wiring, no skew
    mode = 0;
    for (int p = 0; p < NL; p++) begin perm[p] = p; skew[p] = 0; end
    run_scn(10*P);
    expect_good("R4 identity");
    check(first_al >= 2*P, $sformatf("R3 lock too early act=%0d exp>=%0d", first_al, 2*P));

    // random wiring and skew below depth
    for (int it = 0; it < 4; it++) begin
      for (int p = 0; p < NL; p++) perm[p] = p;
      for (int p = NL-1; p > 0; p--) begin
        int j, tmp;
        j = int'($urandom % (p+1));
        tmp = perm[p]; perm[p] = perm[j]; perm[j] = tmp;
      end
      for (int p = 0; p < NL; p++) skew[p] = int'($urandom % D);
      run_scn(10*P);
      expect_good("R5 random");
    end

    // reversed wiring, largest allowed spread
    for (int p = 0; p < NL; p++) perm[p] = NL-1-p;
    skew[0] = 0; skew[1] = D-1; skew[2] = 2; skew[3] = D-1;
    run_scn(10*P);
    expect_good("R5 max skew");

    // skew equal to depth
    for (int p = 0; p < NL; p++) begin perm[p] = p; skew[p] = 0; end
    skew[0] = D;
    run_scn(10*P);
    check(align_error, "R6 align_error act=0 exp=1");
    check(words == 0, $sformatf("R6 words act=%0d exp=0", words));

    // duplicated lane number
    for (int p = 0; p < NL; p++) begin perm[p] = p; skew[p] = 0; end
    perm[2] = 1;
    run_scn(10*P);
    expect_idle("R8 duplicate id");

    // bad inverse field
    for (int p = 0; p < NL; p++) perm[p] = p;
    mode = 2;
    run_scn(10*P);
    expect_idle("R2 bad inverse");

    // out-of-range lane number
    mode = 3;
    run_scn(10*P);
    expect_idle("R2 invalid id");

    // one marker deleted after lock
    mode = 4;
    skew[0] = 1; skew[1] = 3; skew[2] = 0; skew[3] = 2;
    run_scn(12*P);
    check(fell, "R3 aligned drop after missing marker act=0 exp=1");
    check(rose_again, "R3 relock act=0 exp=1");
    check(words_after > 0, $sformatf("R3 words after relock act=%0d exp>0", words_after));
    check(!align_error, "R3 align_error act=1 exp=0");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule